// File: doc/BRIEF.md
# Receiver Status Register Block with Sticky Event Flags

This block sits behind the frame decoder of a serial digital-audio receiver. Once per subframe the decoder presents a strobe together with that subframe's event inputs: a biphase coding error and whether it fell inside a preamble, the channel and user bit, the seven-bit category code, a subcode sync detection and a Q-subcode CRC error. The block also takes a level input that shows whether the receiver holds phase lock. It folds these events into two 8-bit status registers, and a host reads them through a small register-read port.

Four of the flags are sticky. Once set, a sticky flag stays set until the host reads the register that holds it, and the read returns the value from before the clear. The lock indication is live and is not sticky. A separate output marks the start of a subcode block. It stays high for exactly one subframe period, measured from strobe to strobe. While phase lock is absent, every event input is treated as invalid and is dropped.

Top module: `rx_status_regs`

## Requirements
- R1: After reset, the read data and the block-start output are 0, every sticky flag is clear, and register 0 reads 8'h80 while lock is absent.
- R2: Register 0 bit 0 sets on a locked subframe strobe with `bmc_err`=1 and `in_preamble`=0. A coding error flagged inside a preamble has no effect.
- R3: Register 1 bit 7 (track start) sets on a locked strobe with `sf_right`=1, `sf_user`=1 and `sf_category`=7'b1100000. A left-channel user bit or any other category code does not set it.
- R4: Register 1 bit 5 (block start) sets on a locked strobe with `subcode_sync`=1.
- R5: `block_start_pulse` goes high in the cycle after a locked strobe carrying `subcode_sync`. It stays high until the cycle after the next strobe, which reloads it from that strobe's sync input.
- R6: Register 1 bit 6 (Q CRC error) sets on a locked strobe with `qcrc_err`=1 only if subcode sync was seen on an earlier strobe since lock was last gained. Losing lock forgets that sync was seen.
- R7: A sticky flag stays set until its own register is read (`rd_sel`=0 reads register 0, `rd_sel`=1 reads register 1). Reading one register leaves the other register's flags untouched.
- R8: If a set event and a read of the same register occur in the same cycle, the read returns the old value and the flag remains set afterwards.
- R9: `rd_data` shows the selected register's value from before the clear, in the cycle after `rd_en`. It holds its value when no read occurs.
- R10: Register 0 bit 7 equals the inverse of `lock_in`, registered once.
- R11: While `lock_in`=0, strobes set no sticky flag and do not raise `block_start_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sf_valid | input | 1 | One-cycle strobe per decoded subframe |
| sf_right | input | 1 | Subframe belongs to the right channel |
| sf_user | input | 1 | User bit of the subframe |
| sf_category | input | 7 | Current category code |
| bmc_err | input | 1 | Biphase coding error seen in the subframe |
| in_preamble | input | 1 | The coding error lies in a preamble |
| subcode_sync | input | 1 | Subcode sync word completed with this subframe |
| qcrc_err | input | 1 | Q-subcode CRC mismatch reported |
| lock_in | input | 1 | Receiver holds phase lock |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 1 | Register select: 0 or 1 |
| rd_data | output | 8 | Read data, valid the cycle after `rd_en` |
| block_start_pulse | output | 1 | High for one subframe period after subcode sync |

## Verification
The assertions assume that the event inputs carry meaning only in a cycle where `sf_valid` is high. They also assume that `rd_sel` is stable in any cycle where `rd_en` is high. The pulse properties assume that strobes are at least two cycles apart, so that a pulse can be told apart from a hold. The stimulus drives every strobe for exactly one cycle, spaced by idle cycles, and clears all event inputs between strobes. It changes `lock_in` only between strobes, except where the same-cycle read-and-set case is exercised on purpose.

// File: rtl/rx_status_pkg.sv
package rx_status_pkg;
    localparam int REG_W   = 8;
    localparam int CAT_W   = 7;
    localparam int NUM_STK = 4;

    // sticky flag indices
    localparam int STK_CODING = 0;
    localparam int STK_TRACK  = 1;
    localparam int STK_BLOCK  = 2;
    localparam int STK_CRC    = 3;

    // bit positions inside the registers
    localparam int R0_NOLOCK_BIT = 7;
    localparam int R0_CODING_BIT = 0;
    localparam int R1_TRACK_BIT  = 7;
    localparam int R1_CRC_BIT    = 6;
    localparam int R1_BLOCK_BIT  = 5;

    typedef struct packed {
        logic             nolock;
        logic             sync_seen;
        logic [REG_W-1:0] rd_data;
    } ctl_t;
endpackage

// File: rtl/rx_status_sticky.sv
module rx_status_sticky #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    logic [N-1:0] flag_d, flag_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        // set has priority so an event coinciding with a read survives
        always_comb flag_d[i] = set_i[i] | (flag_q[i] & ~clr_i[i]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/rx_status_pulse.sv
module rx_status_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    input  logic fire_i,
    output logic pulse_o
);
    logic pulse_d, pulse_q;

    always_comb begin
        pulse_d = pulse_q;
        if (strobe_i) pulse_d = fire_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= pulse_d;
    end

    assign pulse_o = pulse_q;
endmodule

// File: rtl/rx_status_regs.sv
module rx_status_regs
    import rx_status_pkg::*;
#(
    parameter logic [CAT_W-1:0] TRACK_CATEGORY = 7'b1100000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sf_valid,
    input  logic             sf_right,
    input  logic             sf_user,
    input  logic [CAT_W-1:0] sf_category,
    input  logic             bmc_err,
    input  logic             in_preamble,
    input  logic             subcode_sync,
    input  logic             qcrc_err,
    input  logic             lock_in,
    input  logic             rd_en,
    input  logic             rd_sel,
    output logic [REG_W-1:0] rd_data,
    output logic             block_start_pulse
);
    ctl_t ctl_d, ctl_q;

    logic               ev_ok;
    logic [NUM_STK-1:0] set_vec;
    logic [NUM_STK-1:0] clr_vec;
    logic [NUM_STK-1:0] sticky_q;
    logic [REG_W-1:0]   sr0;
    logic [REG_W-1:0]   sr1;
    logic               rd0, rd1;

    always_comb begin
        ev_ok = sf_valid & lock_in;
        rd0   = rd_en & ~rd_sel;
        rd1   = rd_en &  rd_sel;

        set_vec             = '0;
        set_vec[STK_CODING] = ev_ok & bmc_err & ~in_preamble;
        set_vec[STK_TRACK]  = ev_ok & sf_right & sf_user & (sf_category == TRACK_CATEGORY);
        set_vec[STK_BLOCK]  = ev_ok & subcode_sync;
        set_vec[STK_CRC]    = ev_ok & qcrc_err & ctl_q.sync_seen;

        clr_vec             = '0;
        clr_vec[STK_CODING] = rd0;
        clr_vec[STK_TRACK]  = rd1;
        clr_vec[STK_BLOCK]  = rd1;
        clr_vec[STK_CRC]    = rd1;

        sr0                = '0;
        sr0[R0_NOLOCK_BIT] = ctl_q.nolock;
        sr0[R0_CODING_BIT] = sticky_q[STK_CODING];

        sr1                = '0;
        sr1[R1_TRACK_BIT]  = sticky_q[STK_TRACK];
        sr1[R1_CRC_BIT]    = sticky_q[STK_CRC];
        sr1[R1_BLOCK_BIT]  = sticky_q[STK_BLOCK];

        ctl_d        = ctl_q;
        ctl_d.nolock = ~lock_in;
        if (!lock_in)
            ctl_d.sync_seen = 1'b0;
        else if (ev_ok && subcode_sync)
            ctl_d.sync_seen = 1'b1;
        if (rd_en)
            ctl_d.rd_data = rd_sel ? sr1 : sr0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.nolock    <= 1'b1;
            ctl_q.sync_seen <= 1'b0;
            ctl_q.rd_data   <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    rx_status_sticky #(.N(NUM_STK)) u_sticky (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_vec),
        .clr_i  (clr_vec),
        .flag_o (sticky_q)
    );

    rx_status_pulse u_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (sf_valid),
        .fire_i   (ev_ok & subcode_sync),
        .pulse_o  (block_start_pulse)
    );

    assign rd_data = ctl_q.rd_data;
endmodule

// File: rtl/rx_status_regs_chk.sv
module rx_status_regs_chk
    import rx_status_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               sf_valid,
    input logic               bmc_err,
    input logic               in_preamble,
    input logic               subcode_sync,
    input logic               lock_in,
    input logic               rd_en,
    input logic               rd_sel,
    input logic [REG_W-1:0]   rd_data,
    input logic               block_start_pulse,
    input logic [NUM_STK-1:0] set_vec,
    input logic [NUM_STK-1:0] clr_vec,
    input logic [NUM_STK-1:0] sticky_q,
    input logic [REG_W-1:0]   sr0,
    input logic [REG_W-1:0]   sr1,
    input logic               sync_seen
);
    assert_coding_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sticky_q[STK_CODING]) |-> $past(sf_valid && lock_in && bmc_err && !in_preamble));

    assert_pulse_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(block_start_pulse) |-> $past(sf_valid && lock_in && subcode_sync));

    assert_pulse_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sf_valid |=> $stable(block_start_pulse));

    assert_crc_needs_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sticky_q[STK_CRC]) |-> $past(sync_seen));

    assert_sticky_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_q != '0) |=> (($past(sticky_q) & ~$past(clr_vec) & ~sticky_q) == '0));

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((sticky_q & $past(set_vec)) == $past(set_vec)));

    assert_read_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (rd_data == $past(rd_sel ? sr1 : sr0)));

    assert_read_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    assert_nolock_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_in || !lock_in) |=> (sr0[R0_NOLOCK_BIT] == !$past(lock_in)));

    assert_unlocked_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_in |=> ((sticky_q & ~$past(sticky_q)) == '0));
endmodule

bind rx_status_regs rx_status_regs_chk u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .sf_valid          (sf_valid),
    .bmc_err           (bmc_err),
    .in_preamble       (in_preamble),
    .subcode_sync      (subcode_sync),
    .lock_in           (lock_in),
    .rd_en             (rd_en),
    .rd_sel            (rd_sel),
    .rd_data           (rd_data),
    .block_start_pulse (block_start_pulse),
    .set_vec           (set_vec),
    .clr_vec           (clr_vec),
    .sticky_q          (sticky_q),
    .sr0               (sr0),
    .sr1               (sr1),
    .sync_seen         (ctl_q.sync_seen)
);

// File: tb/rx_status_regs_tb.sv
`timescale 1ns/1ps
module rx_status_regs_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sf_valid = 1'b0, sf_right = 1'b0, sf_user = 1'b0;
    logic [6:0] sf_category = 7'd0;
    logic       bmc_err = 1'b0, in_preamble = 1'b0, subcode_sync = 1'b0, qcrc_err = 1'b0;
    logic       lock_in = 1'b0;
    logic       rd_en = 1'b0, rd_sel = 1'b0;
    logic [7:0] rd_data;
    logic       block_start_pulse;

    localparam logic [6:0] CAT_TRACK = 7'b1100000;

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;
    logic [7:0]  exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    rx_status_regs u_dut (
        .clk (clk), .rst_n (rst_n), .sf_valid (sf_valid), .sf_right (sf_right),
        .sf_user (sf_user), .sf_category (sf_category), .bmc_err (bmc_err),
        .in_preamble (in_preamble), .subcode_sync (subcode_sync), .qcrc_err (qcrc_err),
        .lock_in (lock_in), .rd_en (rd_en), .rd_sel (rd_sel), .rd_data (rd_data),
        .block_start_pulse (block_start_pulse)
    );

    // monitor: pops one expected value per read, one cycle after the strobe
    always @(posedge clk) rd_seen <= rd_en;
    always @(negedge clk) begin
        if (rd_seen) begin
            n_vec++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R9 unexpected read result act=%h exp=none", rd_data);
            end else begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rd_data !== e) begin
                    n_bad++;
                    $display("FAIL %s act=%h exp=%h", t, rd_data, e);
                end
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clear_ev();
        sf_valid = 0; sf_right = 0; sf_user = 0; sf_category = 0;
        bmc_err = 0; in_preamble = 0; subcode_sync = 0; qcrc_err = 0;
        rd_en = 0;
    endtask

    // driver: issue a read and push its expected result
    task automatic rd(input logic sel, input logic [7:0] exp, input string tag);
        @(negedge clk);
        rd_en = 1; rd_sel = sel;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 0;
        idle(1);
    endtask

    task automatic sf(input logic right, input logic user, input logic [6:0] cat,
                      input logic bmc, input logic pre, input logic sync, input logic crc);
        @(negedge clk);
        sf_valid = 1; sf_right = right; sf_user = user; sf_category = cat;
        bmc_err = bmc; in_preamble = pre; subcode_sync = sync; qcrc_err = crc;
        @(negedge clk);
        clear_ev();
        idle(1);
    endtask

    task automatic chk(input logic act, input logic exp, input string tag);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%b exp=%b", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog act=running exp=finished");
            report();
        end
    end

    initial begin
        idle(3);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(block_start_pulse, 1'b0, "R1 pulse after reset");
        n_vec++;
        if (rd_data !== 8'h00) begin n_bad++; $display("FAIL R1 rd_data act=%h exp=00", rd_data); end
        rd(0, 8'h80, "R1 R10 reg0 unlocked");
        rd(1, 8'h00, "R1 reg1 after reset");

        lock_in = 1; idle(2);
        rd(0, 8'h00, "R10 reg0 locked");

        // R2 coding violation
        sf(0, 0, 0, 1, 1, 0, 0);
        rd(0, 8'h00, "R2 preamble error ignored");
        sf(0, 0, 0, 1, 0, 0, 0);
        rd(0, 8'h01, "R2 coding error sets bit0");
        rd(0, 8'h00, "R7 reg0 cleared by read");

        // R3 track start
        sf(0, 1, CAT_TRACK, 0, 0, 0, 0);
        rd(1, 8'h00, "R3 left user bit ignored");
        sf(1, 1, 7'b1100001, 0, 0, 0, 0);
        rd(1, 8'h00, "R3 other category ignored");
        sf(1, 1, CAT_TRACK, 0, 0, 0, 0);
        rd(0, 8'h00, "R7 reg0 read leaves reg1");
        rd(1, 8'h80, "R3 track start set");
        rd(1, 8'h00, "R7 reg1 cleared by read");

        // R6 CRC before sync, R4/R5 sync
        sf(0, 0, 0, 0, 0, 0, 1);
        rd(1, 8'h00, "R6 crc before sync ignored");
        sf(0, 0, 0, 0, 0, 1, 0);
        chk(block_start_pulse, 1'b1, "R5 pulse after sync");
        idle(3);
        chk(block_start_pulse, 1'b1, "R5 pulse held until next strobe");
        @(negedge clk);
        sf_valid = 1;
        @(negedge clk);
        clear_ev();
        chk(block_start_pulse, 1'b0, "R5 pulse ends after next strobe");
        sf(0, 0, 0, 0, 0, 0, 1);
        rd(1, 8'h60, "R4 R6 block start and crc");
        rd(1, 8'h00, "R7 reg1 cleared");

        // R8 set and read in the same cycle
        @(negedge clk);
        sf_valid = 1; bmc_err = 1; rd_en = 1; rd_sel = 0;
        exp_q.push_back(8'h00); tag_q.push_back("R8 read returns old value");
        @(negedge clk);
        clear_ev();
        idle(1);
        rd(0, 8'h01, "R8 flag survives same-cycle read");
        idle(3);
        chk(rd_data == 8'h01, 1'b1, "R9 rd_data holds without read");
        rd(0, 8'h00, "R7 reg0 cleared after R8");

        // R11 unlocked events ignored; R6 sync forgotten
        lock_in = 0; idle(2);
        sf(1, 1, CAT_TRACK, 1, 0, 1, 1);
        chk(block_start_pulse, 1'b0, "R11 no pulse while unlocked");
        rd(0, 8'h80, "R11 R10 reg0 unlocked no flags");
        rd(1, 8'h00, "R11 reg1 unlocked no flags");
        lock_in = 1; idle(2);
        sf(0, 0, 0, 0, 0, 0, 1);
        rd(1, 8'h00, "R6 sync forgotten after lock loss");
        rd(0, 8'h00, "R10 reg0 relocked");

        idle(3);
        done = 1;
        report();
    end
endmodule